// File: doc/BRIEF.md
# Multi-window target address decoder with translation and shared lock

This block sits on the target side of a bus bridge. Each incoming access presents an address and a command type: memory or I/O. The block compares the address against five programmable windows. Windows 0 to 3 are general spaces. Window 4 is the expansion-ROM window, which holds boot code for the host. Each window carries a base, an offset mask, a type bit, an enable bit and a local remap base.

The block reports which window won, one-hot. It forms the local-side address by keeping the offset bits of the incoming address and taking the upper bits from the winning window's remap base. It raises a single-transfer flag when the winner is an I/O window, so the bridge disconnects after one data phase. All results are registered and appear one clock after the request.

The block also keeps one exclusive-access lock that covers every window at once. A master acquires the lock with a locked access that hits any window. While the lock is held, an access that does not carry the lock signal is refused with a retry. A control bit turns the whole feature off. The lock state is driven on an active-low pin so that an external arbiter can enforce atomicity.

Top module: `tgt_window_xlate`

## Requirements
- R1: While reset is asserted and right after it, `out_valid`, `hit_vec`, `local_addr`, `single_xfer` and `retry` are all zero and `lock_n` is 1.
- R2: A window matches a request when its enable bit is 1, its type bit equals `req_io` (1 = I/O, 0 = memory), and the request address equals the window base in every bit where the mask is 0. The results appear on the outputs one clock after the request is sampled.
- R3: A window whose enable bit is 0 never sets its bit in `hit_vec`.
- R4: `hit_vec` bit i stands for window i, and bit 4 is the expansion-ROM window. When several windows match, only the lowest-numbered one is reported.
- R5: On a hit, `local_addr = (req_addr & mask) | (remap & ~mask)`, using the winning window's mask and remap. Mask bits are 1 in the offset field.
- R6: `single_xfer` is 1 exactly when the reported window is an I/O window.
- R7: A request that matches no window gives `hit_vec`, `local_addr` and `single_xfer` all equal to zero.
- R8: A request with `req_valid`, `req_lock` and `lock_enable` all high that matches some window, made while the lock is free, drives `lock_n` low from the next clock onward.
- R9: While the lock is held, a valid request with `req_lock` low returns `retry`=1 and a zero `hit_vec`. A request with `req_lock` high is decoded normally.
- R10: `lock_release` frees the lock at the next clock. It wins over an acquiring request in the same cycle.
- R11: With `lock_enable` low, the lock is never taken, and a lock already held is freed at the next clock.
- R12: `out_valid` repeats `req_valid` one clock later. When it is 0, `hit_vec`, `local_addr`, `single_xfer` and `retry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address phase present this cycle |
| req_addr | input | AW | Target-side address |
| req_io | input | 1 | Command type: 1 = I/O, 0 = memory |
| req_lock | input | 1 | Lock signal asserted by the master with this access |
| lock_release | input | 1 | Master releases the exclusive lock |
| lock_enable | input | 1 | Control bit enabling the lock feature |
| cfg_base | input | NW*AW | Window bases, window i in bits [i*AW +: AW] |
| cfg_mask | input | NW*AW | Offset masks, ones in the offset bits |
| cfg_remap | input | NW*AW | Local remap bases |
| cfg_io | input | NW | Window type bits, 1 = I/O |
| cfg_en | input | NW | Window enable bits |
| out_valid | output | 1 | Registered result is valid |
| hit_vec | output | NW | One-hot winning window |
| local_addr | output | AW | Translated local-side address |
| single_xfer | output | 1 | Disconnect after one transfer |
| retry | output | 1 | Access refused because of a foreign lock |
| lock_n | output | 1 | Active-low lock indication |

## Verification
Lock handling and decoding can act in the same cycle. An acquiring request is itself decoded and reported, so the bench checks that request's `hit_vec` and `local_addr` together with `lock_n` falling at the same clock. The bench also drives `lock_release` in the same cycle as a locked request that would acquire the lock again. The check there is that the request still decodes normally and that `lock_n` returns high, with release winning. A further case refuses a foreign request while the lock is held, judged by `retry`=1 and a zero `hit_vec` in the same result cycle.

// File: rtl/tgt_window_pkg.sv
package tgt_window_pkg;
  typedef enum logic {LK_FREE = 1'b0, LK_HELD = 1'b1} lock_state_e;
  localparam int ROM_WINDOW = 4;
endpackage

// File: rtl/tgt_window_match.sv
module tgt_window_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic          addr_io,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic          win_io,
  input  logic          win_en,
  output logic          hit
);
  logic upper_eq;
  assign upper_eq = ((addr & ~mask) == (base & ~mask));
  assign hit      = win_en && (win_io == addr_io) && upper_eq;
endmodule

// File: rtl/tgt_window_select.sv
module tgt_window_select #(
  parameter int NW = 5,
  parameter int AW = 32
) (
  input  logic [NW-1:0]    match,
  input  logic [AW-1:0]    addr,
  input  logic [NW*AW-1:0] mask_flat,
  input  logic [NW*AW-1:0] remap_flat,
  input  logic [NW-1:0]    io_flat,
  output logic [NW-1:0]    grant,
  output logic             any_hit,
  output logic [AW-1:0]    xlat_addr,
  output logic             io_hit
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NW; i++) begin
      if (match[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    xlat_addr = '0;
    io_hit    = 1'b0;
    for (int i = 0; i < NW; i++) begin
      if (grant[i]) begin
        xlat_addr = xlat_addr | (addr & mask_flat[i*AW +: AW])
                              | (remap_flat[i*AW +: AW] & ~mask_flat[i*AW +: AW]);
        io_hit    = io_hit | io_flat[i];
      end
    end
  end

  assign any_hit = |match;
endmodule

// File: rtl/tgt_window_lock.sv
module tgt_window_lock
  import tgt_window_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic try_acquire,
  input  logic release_i,
  input  logic enable,
  output logic held
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!enable || release_i) begin
      state_d = LK_FREE;
    end else if (try_acquire && (state_q == LK_FREE)) begin
      state_d = LK_HELD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_FREE;
    else        state_q <= state_d;
  end

  assign held = (state_q == LK_HELD);
endmodule

// File: rtl/tgt_window_xlate.sv
module tgt_window_xlate #(
  parameter int NW = 5,
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_io,
  input  logic             req_lock,
  input  logic             lock_release,
  input  logic             lock_enable,
  input  logic [NW*AW-1:0] cfg_base,
  input  logic [NW*AW-1:0] cfg_mask,
  input  logic [NW*AW-1:0] cfg_remap,
  input  logic [NW-1:0]    cfg_io,
  input  logic [NW-1:0]    cfg_en,
  output logic             out_valid,
  output logic [NW-1:0]    hit_vec,
  output logic [AW-1:0]    local_addr,
  output logic             single_xfer,
  output logic             retry,
  output logic             lock_n
);
  logic [NW-1:0] match;
  logic [NW-1:0] grant;
  logic          any_hit;
  logic [AW-1:0] xlat_addr;
  logic          io_hit;
  logic          held;
  logic          refuse;

  for (genvar g = 0; g < NW; g++) begin : g_win
    tgt_window_match #(.AW(AW)) u_match (
      .addr    (req_addr),
      .addr_io (req_io),
      .base    (cfg_base[g*AW +: AW]),
      .mask    (cfg_mask[g*AW +: AW]),
      .win_io  (cfg_io[g]),
      .win_en  (cfg_en[g]),
      .hit     (match[g])
    );
  end

  tgt_window_select #(.NW(NW), .AW(AW)) u_sel (
    .match      (match),
    .addr       (req_addr),
    .mask_flat  (cfg_mask),
    .remap_flat (cfg_remap),
    .io_flat    (cfg_io),
    .grant      (grant),
    .any_hit    (any_hit),
    .xlat_addr  (xlat_addr),
    .io_hit     (io_hit)
  );

  tgt_window_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .try_acquire (req_valid && req_lock && any_hit),
    .release_i   (lock_release),
    .enable      (lock_enable),
    .held        (held)
  );

  assign refuse = req_valid && held && !req_lock;

  logic             valid_d;
  logic [NW-1:0]    hit_d;
  logic [AW-1:0]    addr_d;
  logic             single_d;
  logic             retry_d;

  always_comb begin
    valid_d  = req_valid;
    hit_d    = '0;
    addr_d   = '0;
    single_d = 1'b0;
    retry_d  = refuse;
    if (req_valid && !refuse && any_hit) begin
      hit_d    = grant;
      addr_d   = xlat_addr;
      single_d = io_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      hit_vec     <= '0;
      local_addr  <= '0;
      single_xfer <= 1'b0;
      retry       <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      hit_vec     <= hit_d;
      local_addr  <= addr_d;
      single_xfer <= single_d;
      retry       <= retry_d;
    end
  end

  assign lock_n = !held;
endmodule

// File: rtl/tgt_window_xlate_chk.sv
module tgt_window_xlate_chk #(
  parameter int NW = 5,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_lock,
  input logic          lock_release,
  input logic          lock_enable,
  input logic          out_valid,
  input logic [NW-1:0] hit_vec,
  input logic [AW-1:0] local_addr,
  input logic          single_xfer,
  input logic          retry,
  input logic          lock_n
);
  assert_hit_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_single_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    single_xfer |-> (hit_vec != '0));

  assert_retry_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> (out_valid && hit_vec == '0));

  assert_release_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_release |=> lock_n);

  assert_disable_frees_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_enable |=> lock_n);

  assert_acquire_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> $past(req_valid && req_lock && lock_enable));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (hit_vec == '0 && local_addr == '0 && !single_xfer && !retry));
endmodule

bind tgt_window_xlate tgt_window_xlate_chk #(.NW(NW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_lock     (req_lock),
  .lock_release (lock_release),
  .lock_enable  (lock_enable),
  .out_valid    (out_valid),
  .hit_vec      (hit_vec),
  .local_addr   (local_addr),
  .single_xfer  (single_xfer),
  .retry        (retry),
  .lock_n       (lock_n)
);

// File: tb/tgt_window_xlate_test.sv
`timescale 1ns/1ps
module tgt_window_xlate_test;
  localparam int NW = 5;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_io, req_lock, lock_release, lock_enable;
  logic [AW-1:0] req_addr;
  logic [NW*AW-1:0] cfg_base, cfg_mask, cfg_remap;
  logic [NW-1:0] cfg_io, cfg_en;
  logic out_valid, single_xfer, retry, lock_n;
  logic [NW-1:0] hit_vec;
  logic [AW-1:0] local_addr;

  logic [AW-1:0] wb [NW];
  logic [AW-1:0] wm [NW];
  logic [AW-1:0] wr [NW];
  logic          wi [NW];
  logic          we [NW];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < NW; k++) begin
      cfg_base[k*AW +: AW]  = wb[k];
      cfg_mask[k*AW +: AW]  = wm[k];
      cfg_remap[k*AW +: AW] = wr[k];
      cfg_io[k] = wi[k];
      cfg_en[k] = we[k];
    end
  end

  tgt_window_xlate #(.NW(NW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_io(req_io), .req_lock(req_lock), .lock_release(lock_release),
    .lock_enable(lock_enable), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .cfg_remap(cfg_remap), .cfg_io(cfg_io), .cfg_en(cfg_en),
    .out_valid(out_valid), .hit_vec(hit_vec), .local_addr(local_addr),
    .single_xfer(single_xfer), .retry(retry), .lock_n(lock_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request: drive at negedge, sample shortly after the capturing posedge
  task automatic issue(input logic v, input logic [AW-1:0] a, input logic io,
                       input logic lk, input logic rel);
    @(negedge clk);
    req_valid = v; req_addr = a; req_io = io; req_lock = lk; lock_release = rel;
    @(posedge clk);
    #2;
    req_valid = 1'b0; req_lock = 1'b0; lock_release = 1'b0;
  endtask

  task automatic model(input logic [AW-1:0] a, input logic io,
                       output logic [NW-1:0] h, output logic [AW-1:0] la, output logic s);
    h = '0; la = '0; s = 1'b0;
    for (int k = 0; k < NW; k++) begin
      if (h == '0 && we[k] && wi[k] == io && ((a & ~wm[k]) == (wb[k] & ~wm[k]))) begin
        h[k] = 1'b1;
        la   = (a & wm[k]) | (wr[k] & ~wm[k]);
        s    = wi[k];
      end
    end
  endtask

  initial begin
    logic [NW-1:0] eh;
    logic [AW-1:0] ea;
    logic es;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_io = 1'b0;
    req_lock = 1'b0; lock_release = 1'b0; lock_enable = 1'b0;
    wb[0] = 8'h40; wm[0] = 8'h0F; wr[0] = 8'hA0; wi[0] = 1'b0; we[0] = 1'b1;
    wb[1] = 8'h40; wm[1] = 8'h3F; wr[1] = 8'hC0; wi[1] = 1'b0; we[1] = 1'b1;
    wb[2] = 8'h10; wm[2] = 8'h07; wr[2] = 8'h80; wi[2] = 1'b1; we[2] = 1'b1;
    wb[3] = 8'h80; wm[3] = 8'h7F; wr[3] = 8'h00; wi[3] = 1'b0; we[3] = 1'b0;
    wb[4] = 8'h00; wm[4] = 8'hFF; wr[4] = 8'h00; wi[4] = 1'b0; we[4] = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 hit_vec", hit_vec, 0);
    chk("R1 local_addr", local_addr, 0);
    chk("R1 single_xfer", single_xfer, 0);
    chk("R1 retry", retry, 0);
    chk("R1 lock_n", lock_n, 1);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7: sweep every address, both types, ROM window on and off
    for (int cfg = 0; cfg < 2; cfg++) begin
      we[4] = (cfg == 0);
      for (int io = 0; io < 2; io++) begin
        for (int a = 0; a < 256; a++) begin
          issue(1'b1, a[AW-1:0], io[0], 1'b0, 1'b0);
          model(a[AW-1:0], io[0], eh, ea, es);
          chk("R2 R4 hit_vec", hit_vec, eh);
          chk("R5 R7 local_addr", local_addr, ea);
          chk("R6 single_xfer", single_xfer, es);
          chk("R12 out_valid", out_valid, 1);
          if (a >= 8'h80) chk("R3 disabled window 3", hit_vec[3], 0);
        end
      end
    end
    we[4] = 1'b1;

    // R4 explicit overlap: 0x45 in windows 0,1,4 -> window 0
    issue(1'b1, 8'h45, 1'b0, 1'b0, 1'b0);
    chk("R4 priority", hit_vec, 5'b00001);
    chk("R5 translate", local_addr, 8'hA5);
    // R12 idle
    issue(1'b0, 8'h45, 1'b0, 1'b0, 1'b0);
    chk("R12 idle valid", out_valid, 0);
    chk("R12 idle hit", hit_vec, 0);

    // R11 lock disabled: no acquisition
    lock_enable = 1'b0;
    issue(1'b1, 8'h45, 1'b0, 1'b1, 1'b0);
    chk("R11 no lock when disabled", lock_n, 1);

    // R8 acquire, decoded in the same cycle
    lock_enable = 1'b1;
    issue(1'b1, 8'h12, 1'b1, 1'b1, 1'b0);
    chk("R8 lock_n low", lock_n, 0);
    chk("R8 same-cycle hit", hit_vec, 5'b00100);
    chk("R8 same-cycle addr", local_addr, 8'h82);
    chk("R8 same-cycle single", single_xfer, 1);
    // R9 foreign request refused
    issue(1'b1, 8'h45, 1'b0, 1'b0, 1'b0);
    chk("R9 retry", retry, 1);
    chk("R9 no hit", hit_vec, 0);
    chk("R9 still locked", lock_n, 0);
    // R9 owner decoded
    issue(1'b1, 8'h47, 1'b0, 1'b1, 1'b0);
    chk("R9 owner retry", retry, 0);
    chk("R9 owner hit", hit_vec, 5'b00001);
    chk("R9 owner addr", local_addr, 8'hA7);
    // R10 release wins over same-cycle acquire
    issue(1'b1, 8'h45, 1'b0, 1'b1, 1'b1);
    chk("R10 released", lock_n, 1);
    chk("R10 request decoded", hit_vec, 5'b00001);
    issue(1'b1, 8'h45, 1'b0, 1'b0, 1'b0);
    chk("R10 free after release", retry, 0);
    // R8 miss does not acquire
    we[4] = 1'b0;
    issue(1'b1, 8'hF0, 1'b0, 1'b1, 1'b0);
    chk("R8 miss no lock", lock_n, 1);
    chk("R7 miss hit_vec", hit_vec, 0);
    we[4] = 1'b1;
    // R11 disable frees held lock
    issue(1'b1, 8'h45, 1'b0, 1'b1, 1'b0);
    chk("R8 relock", lock_n, 0);
    @(negedge clk); lock_enable = 1'b0;
    @(posedge clk); #2;
    chk("R11 freed by disable", lock_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule